// File: doc/BRIEF.md
# Allocation Group Branch Limiter

This block sits between a micro-op queue and the out-of-order back end. Every cycle the queue offers up to four micro-ops in program order, each tagged with a flag that marks it as a branch. The block works out how many of them form this cycle's allocation group. It reports that number to the queue, which then pops exactly that many entries.

The group is the longest in-order prefix of the offered micro-ops that meets every limit at once. The limits are the four-slot width, a cap of two branches per group, the free space in a 48-entry branch-order buffer, and the free space in a 60-entry scheduler buffer. When a limit cuts the group short, the block sends the shorter group in that cycle. It does not wait until a full group of four can go.

Execution and retirement return buffer entries through per-cycle release counts. The block also keeps slot-utilization statistics: a running total of unused slots, and four histogram counters of cycles by delivered group size.

Top module: `alloc_branch_limiter`

## Requirements
- R1: `accept_cnt` never exceeds the number of micro-ops offered (`offer_cnt`) and never exceeds 4. An `offer_cnt` above 4 is treated as 4.
- R2: At most 2 branch micro-ops are accepted in one cycle. Bit i of `offer_br` marks slot i (slot 0 is the oldest) as a branch.
- R3: Acceptance is strictly in order. The group ends at the first slot that would break any limit, and no later slot is accepted in that cycle, even one that breaks no limit.
- R4: A branch is not accepted when accepting it would take the branch-order occupancy (`br_occ`) above 48. Non-branch slots that come before it are still accepted.
- R5: No micro-op is accepted when accepting it would take the scheduler occupancy (`sched_occ`) above 60.
- R6: Each release input frees up to 2 entries per cycle. A value of 3 frees 2, and a release never takes an occupancy below zero. Entries freed in a cycle can be used only from the next cycle onward.
- R7: `unused_slots` grows by (4 − `accept_cnt`) on every clock cycle out of reset.
- R8: On every cycle out of reset, four counters advance when the accepted count meets their condition. `cyc_zero` advances when it is 0, `cyc_le1` when it is at most 1, `cyc_le2` when it is at most 2, and `cyc_le3` when it is at most 3.
- R9: A synchronous reset clears both occupancies and all statistics counters.
- R10: At each clock edge, `br_occ` and `sched_occ` each change by the number of branches and micro-ops accepted, minus the entries released in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| offer_cnt | input | 3 | Number of valid micro-ops offered, in slots 0 upward |
| offer_br | input | 4 | Branch flag per offered slot |
| br_release | input | 2 | Branch-order entries freed this cycle |
| sched_release | input | 2 | Scheduler entries freed this cycle |
| accept_cnt | output | 3 | Micro-ops accepted this cycle (combinational) |
| br_occ | output | 6 | Branch-order buffer occupancy |
| sched_occ | output | 6 | Scheduler buffer occupancy |
| unused_slots | output | 32 | Running total of unused allocation slots |
| cyc_zero | output | 32 | Cycles with no micro-op accepted |
| cyc_le1 | output | 32 | Cycles with at most one accepted |
| cyc_le2 | output | 32 | Cycles with at most two accepted |
| cyc_le3 | output | 32 | Cycles with at most three accepted |

## Verification
The hardest situation to reach is a full branch-order buffer while the scheduler still has room. Only then does the branch-occupancy limit cut a group on its own, separate from the per-cycle branch cap. The stimulus offers two branches per cycle without releasing any for 24 cycles, which fills the branch buffer to 48 with the scheduler at 48. It then offers a non-branch followed by a branch and expects a group of one. Next it releases branch entries in a cycle that also offers a branch, and expects that branch to be refused until the following cycle. The stimulus then tops the scheduler up to exactly 60 and checks its release timing in the same way.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
    parameter int unsigned STAT_W = 32;

    typedef struct packed {
        logic [STAT_W-1:0] unused;
        logic [STAT_W-1:0] zero;
        logic [STAT_W-1:0] le1;
        logic [STAT_W-1:0] le2;
        logic [STAT_W-1:0] le3;
    } slot_stats_t;
endpackage

// File: rtl/alloc_group_select.sv
// Picks the longest in-order prefix of offered micro-ops that meets all limits.
module alloc_group_select #(
    parameter int unsigned WIDTH       = 4,
    parameter int unsigned MAX_BR      = 2,
    parameter int unsigned BOB_DEPTH   = 48,
    parameter int unsigned SCHED_DEPTH = 60,
    localparam int unsigned ACC_W      = $clog2(WIDTH + 1),
    localparam int unsigned BR_W       = $clog2(BOB_DEPTH + 1),
    localparam int unsigned SCH_W      = $clog2(SCHED_DEPTH + 1)
) (
    input  logic [ACC_W-1:0] offer_cnt,
    input  logic [WIDTH-1:0] offer_br,
    input  logic [BR_W-1:0]  br_occ,
    input  logic [SCH_W-1:0] sched_occ,
    output logic [ACC_W-1:0] acc_cnt,
    output logic [ACC_W-1:0] acc_br
);
    int  n_take;
    int  n_br;
    int  br_try;
    logic open;

    always_comb begin
        open   = 1'b1;
        n_take = 0;
        n_br   = 0;
        br_try = 0;
        for (int i = 0; i < int'(WIDTH); i++) begin
            if (open) begin
                br_try = n_br + (offer_br[i] ? 1 : 0);
                if (i >= int'(offer_cnt)) begin
                    open = 1'b0;
                end else if (offer_br[i] &&
                             (br_try > int'(MAX_BR) ||
                              int'(br_occ) + br_try > int'(BOB_DEPTH))) begin
                    open = 1'b0;
                end else if (int'(sched_occ) + i + 1 > int'(SCHED_DEPTH)) begin
                    open = 1'b0;
                end else begin
                    n_take = i + 1;
                    n_br   = br_try;
                end
            end
        end
        acc_cnt = ACC_W'(n_take);
        acc_br  = ACC_W'(n_br);
    end
endmodule

// File: rtl/alloc_credit_track.sv
// Occupancy of one buffer: grows by allocations, shrinks by clamped releases.
module alloc_credit_track #(
    parameter int unsigned DEPTH   = 48,
    parameter int unsigned IN_W    = 3,
    parameter int unsigned REL_W   = 2,
    parameter int unsigned MAX_REL = 2,
    localparam int unsigned OCC_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  alloc_n,
    input  logic [REL_W-1:0] rel_n,
    output logic [OCC_W-1:0] occ
);
    typedef struct packed {
        logic [OCC_W-1:0] occ;
    } track_t;

    track_t st_d, st_q;
    int     rel_c;

    always_comb begin
        st_d  = st_q;
        rel_c = int'(rel_n);
        if (rel_c > int'(MAX_REL)) rel_c = int'(MAX_REL);
        if (rel_c > int'(st_q.occ)) rel_c = int'(st_q.occ);
        st_d.occ = OCC_W'(int'(st_q.occ) - rel_c + int'(alloc_n));
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign occ = st_q.occ;
endmodule

// File: rtl/alloc_slot_stats.sv
// Slot-utilization counters driven by the accepted group size.
module alloc_slot_stats
    import alloc_pkg::*;
#(
    parameter int unsigned WIDTH  = 4,
    localparam int unsigned ACC_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] acc_cnt,
    output slot_stats_t      stats
);
    slot_stats_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.unused = st_q.unused + STAT_W'(int'(WIDTH) - int'(acc_cnt));
        if (int'(acc_cnt) == 0) st_d.zero = st_q.zero + 1'b1;
        if (int'(acc_cnt) <= 1) st_d.le1  = st_q.le1 + 1'b1;
        if (int'(acc_cnt) <= 2) st_d.le2  = st_q.le2 + 1'b1;
        if (int'(acc_cnt) <= 3) st_d.le3  = st_q.le3 + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign stats = st_q;
endmodule

// File: rtl/alloc_branch_limiter.sv
module alloc_branch_limiter
    import alloc_pkg::*;
#(
    parameter int unsigned WIDTH       = 4,
    parameter int unsigned MAX_BR      = 2,
    parameter int unsigned BOB_DEPTH   = 48,
    parameter int unsigned SCHED_DEPTH = 60,
    parameter int unsigned MAX_REL     = 2,
    localparam int unsigned ACC_W      = $clog2(WIDTH + 1),
    localparam int unsigned REL_W      = $clog2(MAX_REL + 1),
    localparam int unsigned BR_W       = $clog2(BOB_DEPTH + 1),
    localparam int unsigned SCH_W      = $clog2(SCHED_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  offer_cnt,
    input  logic [WIDTH-1:0]  offer_br,
    input  logic [REL_W-1:0]  br_release,
    input  logic [REL_W-1:0]  sched_release,
    output logic [ACC_W-1:0]  accept_cnt,
    output logic [BR_W-1:0]   br_occ,
    output logic [SCH_W-1:0]  sched_occ,
    output logic [STAT_W-1:0] unused_slots,
    output logic [STAT_W-1:0] cyc_zero,
    output logic [STAT_W-1:0] cyc_le1,
    output logic [STAT_W-1:0] cyc_le2,
    output logic [STAT_W-1:0] cyc_le3
);
    logic [ACC_W-1:0] acc_n;
    logic [ACC_W-1:0] acc_br_n;
    slot_stats_t      stats;

    alloc_group_select #(
        .WIDTH(WIDTH), .MAX_BR(MAX_BR),
        .BOB_DEPTH(BOB_DEPTH), .SCHED_DEPTH(SCHED_DEPTH)
    ) u_sel (
        .offer_cnt(offer_cnt), .offer_br(offer_br),
        .br_occ(br_occ), .sched_occ(sched_occ),
        .acc_cnt(acc_n), .acc_br(acc_br_n)
    );

    alloc_credit_track #(
        .DEPTH(BOB_DEPTH), .IN_W(ACC_W), .REL_W(REL_W), .MAX_REL(MAX_REL)
    ) u_bob (
        .clk(clk), .rst(rst), .alloc_n(acc_br_n), .rel_n(br_release), .occ(br_occ)
    );

    alloc_credit_track #(
        .DEPTH(SCHED_DEPTH), .IN_W(ACC_W), .REL_W(REL_W), .MAX_REL(MAX_REL)
    ) u_sch (
        .clk(clk), .rst(rst), .alloc_n(acc_n), .rel_n(sched_release), .occ(sched_occ)
    );

    alloc_slot_stats #(.WIDTH(WIDTH)) u_stats (
        .clk(clk), .rst(rst), .acc_cnt(acc_n), .stats(stats)
    );

    assign accept_cnt   = acc_n;
    assign unused_slots = stats.unused;
    assign cyc_zero     = stats.zero;
    assign cyc_le1      = stats.le1;
    assign cyc_le2      = stats.le2;
    assign cyc_le3      = stats.le3;
endmodule

// File: rtl/alloc_branch_limiter_chk.sv
module alloc_branch_limiter_chk
    import alloc_pkg::*;
#(
    parameter int unsigned WIDTH       = 4,
    parameter int unsigned MAX_BR      = 2,
    parameter int unsigned BOB_DEPTH   = 48,
    parameter int unsigned SCHED_DEPTH = 60,
    parameter int unsigned MAX_REL     = 2,
    localparam int unsigned ACC_W      = $clog2(WIDTH + 1),
    localparam int unsigned REL_W      = $clog2(MAX_REL + 1),
    localparam int unsigned BR_W       = $clog2(BOB_DEPTH + 1),
    localparam int unsigned SCH_W      = $clog2(SCHED_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [ACC_W-1:0]  offer_cnt,
    input logic [WIDTH-1:0]  offer_br,
    input logic [REL_W-1:0]  br_release,
    input logic [REL_W-1:0]  sched_release,
    input logic [ACC_W-1:0]  accept_cnt,
    input logic [BR_W-1:0]   br_occ,
    input logic [SCH_W-1:0]  sched_occ,
    input logic [STAT_W-1:0] unused_slots,
    input logic [STAT_W-1:0] cyc_zero,
    input logic [STAT_W-1:0] cyc_le1,
    input logic [STAT_W-1:0] cyc_le2,
    input logic [STAT_W-1:0] cyc_le3
);
    AST_ACC_LE_OFFER: assert property (@(posedge clk) disable iff (rst)
        (int'(accept_cnt) <= int'(offer_cnt)) && (int'(accept_cnt) <= int'(WIDTH))); // R1
    AST_BR_RATE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> int'(br_occ) <= int'($past(br_occ)) + int'(MAX_BR)); // R2
    AST_BOB_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(br_occ) <= int'(BOB_DEPTH)); // R4
    AST_SCHED_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(sched_occ) <= int'(SCHED_DEPTH)); // R5
    AST_UNUSED_STEP: assert property (@(posedge clk) disable iff (rst)
        !rst |=> unused_slots == $past(unused_slots) + STAT_W'(int'(WIDTH) - int'($past(accept_cnt)))); // R7
    AST_HIST_ORDER: assert property (@(posedge clk) disable iff (rst)
        (cyc_zero <= cyc_le1) && (cyc_le1 <= cyc_le2) && (cyc_le2 <= cyc_le3)); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (br_occ == '0) && (sched_occ == '0) && (unused_slots == '0)); // R9
    AST_SCHED_STEP: assert property (@(posedge clk) disable iff (rst)
        !rst |=> int'(sched_occ) >= int'($past(sched_occ)) - int'(MAX_REL)); // R6
endmodule

bind alloc_branch_limiter alloc_branch_limiter_chk #(
    .WIDTH(WIDTH), .MAX_BR(MAX_BR), .BOB_DEPTH(BOB_DEPTH),
    .SCHED_DEPTH(SCHED_DEPTH), .MAX_REL(MAX_REL)
) u_chk (.*);

// File: tb/sim_alloc_branch_limiter.sv
`timescale 1ns/1ps
module sim_alloc_branch_limiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  offer_cnt = '0;
    logic [3:0]  offer_br = '0;
    logic [1:0]  br_release = '0;
    logic [1:0]  sched_release = '0;
    logic [2:0]  accept_cnt;
    logic [5:0]  br_occ;
    logic [5:0]  sched_occ;
    logic [31:0] unused_slots, cyc_zero, cyc_le1, cyc_le2, cyc_le3;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    alloc_branch_limiter u0 (
        .clk(clk), .rst(rst), .offer_cnt(offer_cnt), .offer_br(offer_br),
        .br_release(br_release), .sched_release(sched_release),
        .accept_cnt(accept_cnt), .br_occ(br_occ), .sched_occ(sched_occ),
        .unused_slots(unused_slots), .cyc_zero(cyc_zero), .cyc_le1(cyc_le1),
        .cyc_le2(cyc_le2), .cyc_le3(cyc_le3)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Entered and left at a falling edge.
    task automatic step(input int n, input logic [3:0] br, input int brr,
                        input int scr, input int exp_acc, input string tag);
        offer_cnt     = 3'(n);
        offer_br      = br;
        br_release    = 2'(brr);
        sched_release = 2'(scr);
        #1;
        chk(tag, int'(accept_cnt), exp_acc);
        @(posedge clk);
        #1;
        @(negedge clk);
        offer_cnt = '0; offer_br = '0; br_release = '0; sched_release = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        offer_cnt = '0; offer_br = '0; br_release = '0; sched_release = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state(input string tag);
        chk({tag, " br_occ"}, int'(br_occ), 0);
        chk({tag, " sched_occ"}, int'(sched_occ), 0);
        chk({tag, " unused"}, int'(unused_slots), 0);
        chk({tag, " zero"}, int'(cyc_zero), 0);
        chk({tag, " le3"}, int'(cyc_le3), 0);
    endtask

    task automatic t_width();
        step(4, 4'b0000, 0, 0, 4, "R1 four plain");
        step(3, 4'b0000, 0, 0, 3, "R1 three plain");
        step(0, 4'b0000, 0, 0, 0, "R1 none offered");
        step(7, 4'b0000, 0, 0, 4, "R1 offer above width");
        chk("R10 sched_occ after width", int'(sched_occ), 11);
        chk("R10 br_occ after width", int'(br_occ), 0);
    endtask

    task automatic t_branch_cap();
        step(4, 4'b1111, 0, 0, 2, "R2 four branches");
        step(4, 4'b1101, 0, 0, 3, "R2 third branch stops");
        chk("R10 br_occ after cap", int'(br_occ), 4);
        chk("R10 sched_occ after cap", int'(sched_occ), 16);
    endtask

    task automatic t_inorder();
        step(4, 4'b0111, 0, 0, 2, "R3 plain slot after blocked branch");
        chk("R3 br_occ", int'(br_occ), 6);
        chk("R3 sched_occ", int'(sched_occ), 18);
    endtask

    task automatic t_bob_full();
        do_reset();
        for (int k = 0; k < 24; k++) step(2, 4'b0011, 0, 0, 2, "R4 fill");
        chk("R4 br_occ full", int'(br_occ), 48);
        step(2, 4'b0010, 0, 0, 1, "R4 branch refused when full");
        step(1, 4'b0001, 2, 0, 0, "R6 freed branch entries not usable same cycle");
        chk("R6 br_occ after release", int'(br_occ), 46);
        step(4, 4'b1111, 0, 0, 2, "R6 freed branch entries usable next cycle");
        chk("R10 sched_occ", int'(sched_occ), 51);
    endtask

    task automatic t_sched_full();
        step(4, 4'b0000, 0, 0, 4, "R5 fill a");
        step(4, 4'b0000, 0, 0, 4, "R5 fill b");
        step(4, 4'b0000, 0, 0, 1, "R5 last entry");
        chk("R5 sched_occ full", int'(sched_occ), 60);
        step(1, 4'b0000, 0, 2, 0, "R6 freed sched entries not usable same cycle");
        chk("R6 sched_occ after release", int'(sched_occ), 58);
        step(4, 4'b0000, 0, 0, 2, "R6 freed sched entries usable next cycle");
    endtask

    task automatic t_stats();
        do_reset();
        t_reset_state("R9 mid-run reset");
        step(0, 4'b0000, 0, 0, 0, "R8 stats c0");
        step(1, 4'b0000, 0, 0, 1, "R8 stats c1");
        step(2, 4'b0000, 0, 0, 2, "R8 stats c2");
        step(3, 4'b0000, 0, 0, 3, "R8 stats c3");
        step(4, 4'b0000, 0, 0, 4, "R8 stats c4");
        chk("R7 unused total", int'(unused_slots), 10);
        chk("R8 zero", int'(cyc_zero), 1);
        chk("R8 le1", int'(cyc_le1), 2);
        chk("R8 le2", int'(cyc_le2), 3);
        chk("R8 le3", int'(cyc_le3), 4);
    endtask

    task automatic t_release_clamp();
        step(0, 4'b0000, 3, 3, 0, "R6 clamp step");
        chk("R6 br release floors at zero", int'(br_occ), 0);
        chk("R6 sched release capped at two", int'(sched_occ), 8);
    endtask

    initial begin
        do_reset();
        t_reset_state("R9 after reset");
        t_width();
        t_branch_cap();
        t_inorder();
        t_bob_full();
        t_sched_full();
        t_stats();
        t_release_clamp();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule